// File: doc/BRIEF.md
# Sprite Page DMA Engine

This block moves one full 256-byte page of processor address space into the sprite attribute memory. The processor is held while it runs. It watches the processor bus for a write to a trigger register. The data byte of that write selects the source page, and the copy begins at offset zero of that page. After one idle cycle the engine waits for an odd processor cycle. It then runs strict pairs: a read of the source byte, then a write of that byte to the fixed sprite-data port register on the next cycle.

The parity of each processor cycle comes from one of two places, chosen by a parameter. It is either taken from an input or kept by an internal counter that restarts even at reset. The engine raises a stall output for the whole transfer so that the processor gets no clock enable, and it drops it once the last byte has been written.

Top module: `sprite_page_dma`

## Requirements
- R1: A processor write (`cpu_wr` high) to address IO_BASE+0x14 (0x4014 by default) while the engine is passive starts a transfer whose first source address is the written byte in bits 15:8 and zero in bits 7:0.
- R2: In the first cycle after the trigger edge, `busy` is high and `bus_req` is low (one idle cycle).
- R3: A source read (`bus_req` high, `bus_we` low) advances only when the cycle is odd; on an even cycle the read is repeated with the same address, so every write falls on an even cycle.
- R4: Each completed read is followed in the next cycle by a write (`bus_we` high) to address 0x2004 whose data equals the byte returned on `mem_rdata` during that read.
- R5: A transfer moves exactly 256 bytes, reading source offsets 0x00 through 0xFF in increasing order. It ends after the 256th write.
- R6: `cpu_stall` equals `busy` in every cycle. It stays high for 513 cycles when the trigger cycle is odd and for 514 when the trigger cycle is even.
- R7: A trigger write that arrives while a transfer is running is ignored: the source page does not change, and no second transfer follows.
- R8: While `rst_n` is low, and in the cycle after a reset edge, `busy`, `bus_req`, `bus_we` and `cpu_stall` are low, even if reset arrives during a transfer.
- R9: Writes to any other address, and a trigger-address access with `cpu_wr` low, do not start a transfer.
- R10: With EXT_PARITY=0 the internal parity is even in the first cycle after reset and alternates every cycle. The engine then behaves exactly like one fed that same parity on `cyc_odd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Processor bus write strobe |
| cpu_addr | input | ADDR_W | Processor bus address |
| cpu_wdata | input | DATA_W | Processor bus write data |
| cyc_odd | input | 1 | High in odd processor cycles (used when EXT_PARITY=1) |
| mem_rdata | input | DATA_W | Read data returned for `bus_addr` |
| cpu_stall | output | 1 | Withholds the processor clock enable |
| busy | output | 1 | High from the cycle after the trigger through the last write |
| bus_req | output | 1 | Engine owns the bus (read or write cycle) |
| bus_addr | output | ADDR_W | Source address on reads, port address on writes |
| bus_wdata | output | DATA_W | Captured byte on writes |
| bus_we | output | 1 | Write strobe to the sprite-data port |

## Verification
The bench builds two copies with default widths: one takes parity from `cyc_odd` and one keeps its own counter. Both are driven from the same bus and compared cycle by cycle, which puts the internal counter's reset phase within reach. The default 256-byte page lets full transfers be checked end to end. This covers the top page 0xFF and page 0x00, triggers in both odd and even cycles (the 513- and 514-cycle stalls), a trigger injected mid-transfer, and a reset that cuts a transfer short.

// File: rtl/spdma_pkg.sv
// Shared types for the sprite page DMA engine.
// Assumes: a four-state sequencer is enough to describe every phase.
package spdma_pkg;

    typedef enum logic [1:0] {
        ST_PASSIVE = 2'd0,
        ST_IDLE    = 2'd1,
        ST_READ    = 2'd2,
        ST_WRITE   = 2'd3
    } dma_state_e;

endpackage

// File: rtl/spdma_trig.sv
// Trigger decoder: detects a processor write to the trigger register.
// Assumes: a trigger is only accepted while the sequencer is passive.
module spdma_trig #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
    input  logic              accept,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              fire
);

    // Raise fire for a matching write when the engine can take it.
    always_comb begin
        fire = accept && cpu_wr && (cpu_addr == TRIG_ADDR);
    end

endmodule

// File: rtl/spdma_parity.sv
// Parity source: gives the odd/even phase of the current processor cycle.
// Assumes: internal mode starts even in the first cycle after reset.
module spdma_parity #(
    parameter bit EXT_PARITY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_odd,
    output logic odd
);

    generate
        if (EXT_PARITY) begin : g_ext
            // Pass the externally supplied phase through.
            always_comb begin
                odd = cyc_odd;
            end
        end else begin : g_int
            logic par_q;
            // Toggle the phase every cycle from an even start.
            always_ff @(posedge clk) begin
                if (!rst_n) par_q <= 1'b0;
                else        par_q <= ~par_q;
            end
            always_comb begin
                odd = par_q;
            end
        end
    endgenerate

endmodule

// File: rtl/spdma_seq.sv
// Sequencer: idle cycle, odd-aligned reads, read/write pairs, 256-byte count.
// Assumes: rdata is valid in the same cycle the source address is driven.
module spdma_seq
    import spdma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int XFER_LEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] page,
    input  logic              odd,
    input  logic [DATA_W-1:0] rdata,
    output dma_state_e        state,
    output logic [ADDR_W-1:0] src,
    output logic [DATA_W-1:0] hold
);

    localparam int CNT_W = $clog2(XFER_LEN);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(XFER_LEN - 1);

    logic [CNT_W-1:0] remain;

    // Advance the transfer phase, source pointer, count and data latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_PASSIVE;
            src    <= '0;
            remain <= '0;
            hold   <= '0;
        end else begin
            case (state)
                ST_PASSIVE: begin
                    if (fire) begin
                        state  <= ST_IDLE;
                        src    <= ADDR_W'(page) << CNT_W;
                        remain <= CNT_INIT;
                    end
                end
                ST_IDLE: begin
                    state <= ST_READ;
                end
                ST_READ: begin
                    if (odd) begin
                        hold  <= rdata;
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (remain == '0) begin
                        state <= ST_PASSIVE;
                    end else begin
                        remain <= remain - CNT_W'(1);
                        src    <= src + ADDR_W'(1);
                        state  <= ST_READ;
                    end
                end
                default: state <= ST_PASSIVE;
            endcase
        end
    end

endmodule

// File: rtl/spdma_drive.sv
// Bus driver: turns the sequencer phase into stall, request, address, data, strobe.
// Assumes: outputs depend only on registered state (no input-to-output path).
module spdma_drive
    import spdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004
) (
    input  dma_state_e        state,
    input  logic [ADDR_W-1:0] src,
    input  logic [DATA_W-1:0] hold,
    output logic              cpu_stall,
    output logic              busy,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we
);

    // Decode the phase into the bus-side signals.
    always_comb begin
        busy      = (state != ST_PASSIVE);
        cpu_stall = busy;
        bus_req   = (state == ST_READ) || (state == ST_WRITE);
        bus_we    = (state == ST_WRITE);
        bus_addr  = '0;
        bus_wdata = '0;
        if (state == ST_READ) begin
            bus_addr = src;
        end else if (state == ST_WRITE) begin
            bus_addr  = PORT_ADDR;
            bus_wdata = hold;
        end
    end

endmodule

// File: rtl/sprite_page_dma.sv
// Top: copies one source page into the sprite-data port while stalling the processor.
// Assumes: the processor honours cpu_stall, and mem_rdata answers bus_addr combinationally.
module sprite_page_dma
    import spdma_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int XFER_LEN = 256,
    parameter logic [ADDR_W-1:0] IO_BASE   = 16'h4000,
    parameter logic [ADDR_W-1:0] TRIG_OFS  = 16'h0014,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004,
    parameter bit EXT_PARITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cyc_odd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              cpu_stall,
    output logic              busy,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we
);

    localparam logic [ADDR_W-1:0] TRIG_ADDR = IO_BASE + TRIG_OFS;

    dma_state_e        state;
    logic [ADDR_W-1:0] src;
    logic [DATA_W-1:0] hold;
    logic              fire;
    logic              par_odd;
    logic              passive;

    // Trigger is only open while no transfer is pending or running.
    always_comb begin
        passive = (state == ST_PASSIVE);
    end

    spdma_trig #(
        .ADDR_W   (ADDR_W),
        .TRIG_ADDR(TRIG_ADDR)
    ) u_trig (
        .accept  (passive),
        .cpu_wr  (cpu_wr),
        .cpu_addr(cpu_addr),
        .fire    (fire)
    );

    spdma_parity #(
        .EXT_PARITY(EXT_PARITY)
    ) u_parity (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_odd(cyc_odd),
        .odd    (par_odd)
    );

    spdma_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .XFER_LEN(XFER_LEN)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (fire),
        .page (cpu_wdata),
        .odd  (par_odd),
        .rdata(mem_rdata),
        .state(state),
        .src  (src),
        .hold (hold)
    );

    spdma_drive #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PORT_ADDR(PORT_ADDR)
    ) u_drive (
        .state    (state),
        .src      (src),
        .hold     (hold),
        .cpu_stall(cpu_stall),
        .busy     (busy),
        .bus_req  (bus_req),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we)
    );

endmodule

// File: rtl/sprite_page_dma_chk.sv
// Checker: temporal properties of the sprite page DMA engine, bound to the top.
// Assumes: par_odd is the phase the sequencer itself uses.
module sprite_page_dma_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int XFER_LEN = 256,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h2004
) (
    input logic              clk,
    input logic              rst_n,
    input logic              par_odd,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              cpu_stall,
    input logic              busy,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we
);

    localparam int MIN_LEN = 2 * XFER_LEN + 1;
    localparam int MAX_LEN = 2 * XFER_LEN + 2;
    localparam int LEN_W   = $clog2(MAX_LEN + 2) + 1;

    logic [LEN_W-1:0]  run_len;
    logic [ADDR_W-1:0] last_rd;

    // Count cycles of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + LEN_W'(1);
        else           run_len <= '0;
    end

    // Remember the most recent source read address.
    always_ff @(posedge clk) begin
        if (!rst_n)                  last_rd <= '0;
        else if (bus_req && !bus_we) last_rd <= bus_addr;
    end

    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> (!busy && !bus_req && !bus_we && !cpu_stall));

    assert_idle_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cpu_wr && cpu_addr == TRIG_ADDR) |=> (busy && !bus_req));

    assert_even_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !par_odd) |=> (bus_req && !bus_we && $stable(bus_addr)));

    assert_write_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> !par_odd);

    assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && par_odd) |=> (bus_we && bus_addr == PORT_ADDR));

    assert_wdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_wdata == $past(mem_rdata)));

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && $past(bus_we)) |-> (bus_addr == last_rd + ADDR_W'(1)));

    assert_stall_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && run_len != '0) |->
        (run_len == LEN_W'(MIN_LEN) || run_len == LEN_W'(MAX_LEN)));

    assert_stall_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cpu_stall);

endmodule

bind sprite_page_dma sprite_page_dma_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .XFER_LEN (XFER_LEN),
    .TRIG_ADDR(TRIG_ADDR),
    .PORT_ADDR(PORT_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_odd  (par_odd),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .mem_rdata(mem_rdata),
    .cpu_stall(cpu_stall),
    .busy     (busy),
    .bus_req  (bus_req),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we)
);

// File: tb/sprite_page_dma_bench.sv
module sprite_page_dma_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] TRIG = 16'h4014;
    localparam logic [15:0] PORT = 16'h2004;

    typedef struct packed {
        logic [7:0] page;
        logic       odd;
        logic [9:0] len;
        logic       inj;
    } vec_t;

    localparam vec_t VECS [0:4] = '{
        '{8'h02, 1'b1, 10'd513, 1'b0},
        '{8'h07, 1'b0, 10'd514, 1'b0},
        '{8'hFF, 1'b1, 10'd513, 1'b0},
        '{8'h00, 1'b0, 10'd514, 1'b0},
        '{8'h3C, 1'b1, 10'd513, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cyc_odd = 1'b0;

    logic [7:0]  rdata_e, rdata_i;
    logic        stall_e, busy_e, req_e, we_e;
    logic        stall_i, busy_i, req_i, we_i;
    logic [15:0] addr_e, addr_i;
    logic [7:0]  wdata_e, wdata_i;

    int n_checks = 0;
    int n_fail = 0;
    int diff_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Memory models: byte value is a function of the address.
    assign rdata_e = addr_e[7:0] ^ addr_e[15:8] ^ 8'h5A;
    assign rdata_i = addr_i[7:0] ^ addr_i[15:8] ^ 8'h5A;

    sprite_page_dma #(.EXT_PARITY(1'b1)) u_sprite_page_dma (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cyc_odd(cyc_odd), .mem_rdata(rdata_e),
        .cpu_stall(stall_e), .busy(busy_e), .bus_req(req_e),
        .bus_addr(addr_e), .bus_wdata(wdata_e), .bus_we(we_e)
    );

    sprite_page_dma #(.EXT_PARITY(1'b0)) u_sprite_page_dma_intpar (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cyc_odd(1'b0), .mem_rdata(rdata_i),
        .cpu_stall(stall_i), .busy(busy_i), .bus_req(req_i),
        .bus_addr(addr_i), .bus_wdata(wdata_i), .bus_we(we_i)
    );

    function automatic logic [7:0] exp_byte(input logic [7:0] pg, input int k);
        return 8'(k) ^ pg ^ 8'h5A;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Move to the next negedge, compare both copies, advance the parity.
    task automatic next_cycle();
        @(negedge clk);
        if ({stall_e, busy_e, req_e, we_e, addr_e, wdata_e} !=
            {stall_i, busy_i, req_i, we_i, addr_i, wdata_i}) diff_cnt++;
        cyc_odd = ~cyc_odd;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cpu_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc_odd = 1'b0;
    endtask

    task automatic run_xfer(input vec_t v);
        int stall = 0, k = 0, bad_rd = 0, bad_wr = 0, odd_wr = 0, bad_st = 0;
        int first_rd = -1;
        int d0 = diff_cnt;
        while (cyc_odd != v.odd) next_cycle();
        cpu_wr = 1'b1; cpu_addr = TRIG; cpu_wdata = v.page;
        next_cycle();
        cpu_wr = 1'b0;
        // R2: first cycle after trigger is the idle cycle
        check(busy_e && !req_e, "R2", {30'd0, busy_e, req_e}, 2);
        for (int g = 0; g < 2000; g++) begin
            if (!busy_e) break;
            stall++;
            if (stall_e != busy_e) bad_st++;
            if (req_e && !we_e) begin
                if (first_rd < 0) first_rd = int'(addr_e);
                if (addr_e != {v.page, 8'(k)}) bad_rd++;
            end
            if (we_e) begin
                if (addr_e != PORT || wdata_e != exp_byte(v.page, k)) bad_wr++;
                if (cyc_odd) odd_wr++;
                k++;
            end
            if (v.inj && k == 10 && !we_e) begin
                cpu_wr = 1'b1; cpu_addr = TRIG; cpu_wdata = v.page ^ 8'h11;
            end
            next_cycle();
            cpu_wr = 1'b0;
        end
        check(first_rd == int'({v.page, 8'h00}), "R1", first_rd, int'({v.page, 8'h00}));
        check(odd_wr == 0, "R3", odd_wr, 0);
        check(bad_wr == 0, "R4", bad_wr, 0);
        check(k == 256 && bad_rd == 0, v.inj ? "R7" : "R5", k - bad_rd, 256);
        check(stall == int'(v.len) && bad_st == 0, "R6", stall, int'(v.len));
        check(diff_cnt == d0, "R10", diff_cnt - d0, 0);
        next_cycle();
        check(!busy_e, v.inj ? "R7" : "R5", busy_e, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL R5 watchdog: actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R8: reset state
        check(!busy_e && !req_e && !we_e && !stall_e, "R8",
              {28'd0, busy_e, req_e, we_e, stall_e}, 0);

        // R9: non-trigger accesses
        cpu_wr = 1'b1; cpu_addr = 16'h4015; cpu_wdata = 8'h03;
        next_cycle();
        cpu_wr = 1'b0; cpu_addr = TRIG;
        check(!busy_e, "R9", busy_e, 0);
        next_cycle();
        check(!busy_e, "R9", busy_e, 0);
        cpu_wr = 1'b1; cpu_addr = 16'h2014;
        next_cycle();
        cpu_wr = 1'b0;
        check(!busy_e, "R9", busy_e, 0);

        // Table of transfer vectors (R1..R7, R10)
        for (int i = 0; i < 5; i++) run_xfer(VECS[i]);

        // R8: reset in the middle of a transfer
        cpu_wr = 1'b1; cpu_addr = TRIG; cpu_wdata = 8'h44;
        next_cycle();
        cpu_wr = 1'b0;
        repeat (40) next_cycle();
        check(busy_e, "R8", busy_e, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy_e && !we_e && !req_e && !stall_e, "R8",
              {28'd0, busy_e, req_e, we_e, stall_e}, 0);
        do_reset();
        check(!busy_e && !we_e, "R8", {30'd0, busy_e, we_e}, 0);

        // R10: internal phase starts even after a fresh reset
        run_xfer('{8'h81, 1'b0, 10'd514, 1'b0});

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule